// File: doc/BRIEF.md
# Controller Memory Buffer Window Controller

This block holds the control and status registers through which a host turns on a memory buffer owned by the controller and places it in host address space. It also decodes host addresses against that window. Software writes a 64-bit control word through a 32-bit register port, either one half at a time or as one wide write. It reads back the location, size and status words. The decoder flags every host address that falls inside the live window and gives the byte offset of that address from the window start.

The window goes live only after two enables are written together. Setting the register-enable bit fills the location and size words. Setting the memory-space-enable bit in the same low-half write latches the programmed base and opens the window. A base whose window would run past the top of the 64-bit address space is refused. The refusal is recorded in a sticky status bit. A compile-time legacy variant decodes against the base address of the fixed BAR instead of the programmed base. That variant comes out of reset with the window already open. A second compile-time option says whether the controller advertises buffer support at all; without it the control word ignores writes.

Top module: `cmb_window_ctrl`

## Requirements
- R1: After reset (non-legacy), reads of the location word (offset 0x38), size word (0x3C), status word (0x58) and both control halves (0x50, 0x54) return 0, and no host address hits.
- R2: A narrow write to 0x50 replaces control bits 31:0 and a narrow write to 0x54 replaces bits 63:32. A wide write to 0x50 replaces all 64 bits, with the high word supplied on the second data input. Reads of 0x50 and 0x54 return the two halves.
- R3: When buffer support is not advertised, every write to the control word is ignored: both halves, the location word and the size word stay 0 and no address hits.
- R4: A low-half write with bit 0 = 1 sets the location word to the BAR indicator (BAR_IDX in bits 2:0, all other bits 0). It sets the size word to: bit 0 = 1 (submission queues), bit 1 = 0 (completion queues), bits 2, 3 and 4 = 1 (lists, read data, write data), bits 11:8 = 2 (MiB unit), and bits 31:12 = SIZE_MIB. With the defaults this value is 0x421D.
- R5: A low-half write with bit 0 = 0 clears the location and size words to 0.
- R6: A low-half write with bits 0 and 1 both 1 takes the base from bits 63:12 of the updated control word, shifted left by 12. If the window does not wrap, it opens the window. An address hits when base <= addr < base + window size.
- R7: Every accepted low-half write first closes the window. A write that does not set both bits 0 and 1 leaves it closed.
- R8: If base + window size reaches or passes 2^64, status bit 0 is set and the window stays closed. The bit stays set until reset.
- R9: A narrow write to 0x54 leaves the window state and the decode base unchanged.
- R10: While the address hits, the offset output equals the address minus the active base. Otherwise it is 0.
- R11: Writes to the size word (0x3C) are ignored.
- R12: In legacy mode the location and size words are filled at reset and the window is open with no host write. Decode then uses the BAR base input, not the programmed base.
- R13: The window size in bytes is the size field times 2^(12 + 4 x unit), which is SIZE_MIB MiB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Register write byte offset |
| wr_data_i | input | 32 | Write data, low word |
| wr_wide_i | input | 1 | 64-bit write; the high word is on wr_data_hi_i |
| wr_data_hi_i | input | 32 | Write data, high word for wide writes |
| rd_addr_i | input | 12 | Register read byte offset |
| rd_data_o | output | 32 | Register read data (combinational) |
| bar_base_i | input | 64 | Base address of the fixed BAR, used in legacy mode |
| host_addr_i | input | 64 | Host address to decode |
| hit_o | output | 1 | Address lies inside the live window |
| offset_o | output | 64 | Offset of the address from the window base |

## Verification
A register write and the address decode work in the same cycle. The sharpest case is a high-half write that lands while the window is live, with the decoder probing the old base. The bench places the probe directly after that write and expects the hit and offset to be unchanged, while the readback shows the new high word. The opposite case is a low-half write that closes the window. There the very next probe must miss even though the location word stays filled. Wrap refusal is provoked with a base whose window ends exactly at 2^64, and the base one window below it is then expected to open normally.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  localparam logic [11:0] OFS_LOC     = 12'h038;
  localparam logic [11:0] OFS_SIZE    = 12'h03C;
  localparam logic [11:0] OFS_CTRL_LO = 12'h050;
  localparam logic [11:0] OFS_CTRL_HI = 12'h054;
  localparam logic [11:0] OFS_STS     = 12'h058;

  localparam logic [3:0] SZ_UNIT_MIB = 4'd2;

  function automatic logic [31:0] size_word(input int unsigned mib);
    logic [31:0] w;
    w        = '0;
    w[0]     = 1'b1;  // submission queues
    w[1]     = 1'b0;  // completion queues
    w[2]     = 1'b1;  // lists
    w[3]     = 1'b1;  // read data
    w[4]     = 1'b1;  // write data
    w[11:8]  = SZ_UNIT_MIB;
    w[31:12] = mib[19:0];
    return w;
  endfunction

  function automatic logic [63:0] win_bytes(input logic [31:0] szw);
    return 64'(szw[31:12]) << (12 + 4 * int'(szw[11:8]));
  endfunction
endpackage

// File: rtl/cmb_regs.sv
module cmb_regs
  import cmb_pkg::*;
#(
  parameter bit          CAP_EN    = 1'b1,
  parameter bit          LEGACY    = 1'b0,
  parameter int unsigned BAR_IDX   = 2,
  parameter int unsigned SIZE_MIB  = 4,
  parameter logic [63:0] WIN_BYTES = 64'h40_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [11:0] wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic        wr_wide_i,
  input  logic [31:0] wr_data_hi_i,
  output logic [63:0] ctrl_q,
  output logic [31:0] loc_q,
  output logic [31:0] sz_q,
  output logic [31:0] sts_q,
  output logic [63:0] prog_base_q,
  output logic        win_en_q
);
  localparam logic [31:0] LOC_VAL = {29'b0, 3'(BAR_IDX)};
  localparam logic [31:0] SZ_VAL  = size_word(SIZE_MIB);

  logic        wr_lo, wr_hi;
  logic [63:0] ctrl_nxt, base_cand;
  logic [64:0] end_cand;
  logic        wraps;

  assign wr_lo     = CAP_EN && wr_en_i && (wr_addr_i == OFS_CTRL_LO);
  assign wr_hi     = CAP_EN && wr_en_i && (wr_addr_i == OFS_CTRL_HI) && !wr_wide_i;
  assign ctrl_nxt  = wr_wide_i ? {wr_data_hi_i, wr_data_i} : {ctrl_q[63:32], wr_data_i};
  assign base_cand = {ctrl_nxt[63:12], 12'b0};
  assign end_cand  = {1'b0, base_cand} + {1'b0, WIN_BYTES};
  assign wraps     = end_cand[64];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      loc_q       <= LEGACY ? LOC_VAL : '0;
      sz_q        <= LEGACY ? SZ_VAL : '0;
      sts_q       <= '0;
      prog_base_q <= '0;
      win_en_q    <= LEGACY;
    end else if (wr_lo) begin
      ctrl_q   <= ctrl_nxt;
      win_en_q <= 1'b0;
      if (wr_data_i[0]) begin
        loc_q <= LOC_VAL;
        sz_q  <= SZ_VAL;
        if (wr_data_i[1]) begin
          if (wraps) begin
            sts_q[0] <= 1'b1;
          end else begin
            prog_base_q <= base_cand;
            win_en_q    <= 1'b1;
          end
        end
      end else begin
        loc_q <= '0;
        sz_q  <= '0;
      end
    end else if (wr_hi) begin
      ctrl_q[63:32] <= wr_data_i;
    end
  end
endmodule

// File: rtl/cmb_decode.sv
module cmb_decode #(
  parameter int unsigned AW        = 64,
  parameter logic [63:0] WIN_BYTES = 64'h40_0000
) (
  input  logic          win_en_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [AW-1:0] offset_o
);
  logic [AW:0] win_end;
  logic        in_range;

  // one extra bit so a window at the top of the space compares correctly
  assign win_end  = {1'b0, base_i} + {1'b0, WIN_BYTES[AW-1:0]};
  assign in_range = (addr_i >= base_i) && ({1'b0, addr_i} < win_end);
  assign hit_o    = win_en_i && in_range;
  assign offset_o = hit_o ? (addr_i - base_i) : '0;
endmodule

// File: rtl/cmb_window_ctrl.sv
module cmb_window_ctrl
  import cmb_pkg::*;
#(
  parameter bit          CAP_EN   = 1'b1,
  parameter bit          LEGACY   = 1'b0,
  parameter int unsigned BAR_IDX  = 2,
  parameter int unsigned SIZE_MIB = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [11:0] wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic        wr_wide_i,
  input  logic [31:0] wr_data_hi_i,
  input  logic [11:0] rd_addr_i,
  output logic [31:0] rd_data_o,
  input  logic [63:0] bar_base_i,
  input  logic [63:0] host_addr_i,
  output logic        hit_o,
  output logic [63:0] offset_o
);
  localparam logic [63:0] WIN_BYTES = win_bytes(size_word(SIZE_MIB));

  logic [63:0] ctrl_q, prog_base_q, act_base;
  logic [31:0] loc_q, sz_q, sts_q;
  logic        win_en_q;

  cmb_regs #(
    .CAP_EN(CAP_EN), .LEGACY(LEGACY), .BAR_IDX(BAR_IDX),
    .SIZE_MIB(SIZE_MIB), .WIN_BYTES(WIN_BYTES)
  ) regs_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .wr_wide_i, .wr_data_hi_i,
    .ctrl_q, .loc_q, .sz_q, .sts_q, .prog_base_q, .win_en_q
  );

  generate
    if (LEGACY) begin : g_bar_base
      assign act_base = bar_base_i;
    end else begin : g_prog_base
      assign act_base = prog_base_q;
    end
  endgenerate

  cmb_decode #(.AW(64), .WIN_BYTES(WIN_BYTES)) dec_i (
    .win_en_i(win_en_q), .base_i(act_base), .addr_i(host_addr_i),
    .hit_o, .offset_o
  );

  always_comb begin
    unique case (rd_addr_i)
      OFS_LOC:     rd_data_o = loc_q;
      OFS_SIZE:    rd_data_o = sz_q;
      OFS_CTRL_LO: rd_data_o = ctrl_q[31:0];
      OFS_CTRL_HI: rd_data_o = ctrl_q[63:32];
      OFS_STS:     rd_data_o = sts_q;
      default:     rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/cmb_window_chk.sv
module cmb_window_chk
  import cmb_pkg::*;
#(
  parameter logic [63:0] WIN_BYTES = 64'h40_0000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [11:0] wr_addr_i,
  input logic [31:0] wr_data_i,
  input logic        wr_wide_i,
  input logic        win_en_q,
  input logic [63:0] act_base,
  input logic [31:0] sz_q,
  input logic [31:0] sts_q,
  input logic        hit_o,
  input logic [63:0] offset_o
);
  assert_closed_no_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_en_q |-> !hit_o);

  assert_offset_in_window_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (offset_o < WIN_BYTES));

  assert_offset_zero_on_miss_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (offset_o == 64'd0));

  assert_invalid_base_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_q[0] |=> sts_q[0]);

  assert_hi_write_keeps_window_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == OFS_CTRL_HI && !wr_wide_i) |=> ($stable(win_en_q) && $stable(act_base)));

  assert_size_write_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == OFS_SIZE) |=> $stable(sz_q));

  assert_partial_enable_closes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == OFS_CTRL_LO && !(wr_data_i[0] && wr_data_i[1])) |=> !win_en_q);
endmodule

bind cmb_window_ctrl cmb_window_chk #(.WIN_BYTES(WIN_BYTES)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .wr_wide_i(wr_wide_i), .win_en_q(win_en_q),
  .act_base(act_base), .sz_q(sz_q), .sts_q(sts_q), .hit_o(hit_o), .offset_o(offset_o)
);

// File: tb/cmb_window_ctrl_tb_top.sv
`timescale 1ns/1ps
module cmb_window_ctrl_tb_top;
  localparam logic [63:0] WIN  = 64'h40_0000;
  localparam logic [31:0] SZV  = 32'h0000_421D;
  localparam logic [31:0] LOCV = 32'd2;
  localparam logic [63:0] BAR  = 64'h0000_00F0_0000_0000;
  localparam logic [11:0] A_LOC = 12'h038, A_SZ = 12'h03C, A_LO = 12'h050,
                          A_HI = 12'h054, A_STS = 12'h058;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        wr_en = 1'b0, wr_wide = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, wr_data_hi = '0;
  logic [63:0] host_addr = '0;
  logic [31:0] rd_m, rd_l, rd_n;
  logic        hit_m, hit_l, hit_n;
  logic [63:0] off_m, off_l, off_n;

  cmb_window_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_wide_i(wr_wide), .wr_data_hi_i(wr_data_hi),
    .rd_addr_i(rd_addr), .rd_data_o(rd_m), .bar_base_i(BAR),
    .host_addr_i(host_addr), .hit_o(hit_m), .offset_o(off_m));

  cmb_window_ctrl #(.LEGACY(1'b1)) dut_leg_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_wide_i(wr_wide), .wr_data_hi_i(wr_data_hi),
    .rd_addr_i(rd_addr), .rd_data_o(rd_l), .bar_base_i(BAR),
    .host_addr_i(host_addr), .hit_o(hit_l), .offset_o(off_l));

  cmb_window_ctrl #(.CAP_EN(1'b0)) dut_nocap_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_wide_i(wr_wide), .wr_data_hi_i(wr_data_hi),
    .rd_addr_i(rd_addr), .rd_data_o(rd_n), .bar_base_i(BAR),
    .host_addr_i(host_addr), .hit_o(hit_n), .offset_o(off_n));

  typedef struct {
    int          sel;
    logic        hit;
    logic [63:0] off;
    logic [31:0] rd;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  logic probe_v = 1'b0;
  int   total = 0, bad = 0;
  bit   done = 0;

  // monitor: compare at the falling edge inside the probe cycle
  always @(negedge clk) begin
    if (probe_v && exp_q.size() > 0) begin
      exp_t e;
      logic ah;
      logic [63:0] ao;
      logic [31:0] ar;
      e = exp_q.pop_front();
      case (e.sel)
        1:       begin ah = hit_l; ao = off_l; ar = rd_l; end
        2:       begin ah = hit_n; ao = off_n; ar = rd_n; end
        default: begin ah = hit_m; ao = off_m; ar = rd_m; end
      endcase
      total++;
      if (ah !== e.hit || ao !== e.off || ar !== e.rd) begin
        bad++;
        $display("FAIL %s dut%0d: hit=%0b off=%h rd=%h expected hit=%0b off=%h rd=%h",
                 e.tag, e.sel, ah, ao, ar, e.hit, e.off, e.rd);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input logic wide = 1'b0, input logic [31:0] dh = '0);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_wide = wide; wr_data_hi = dh;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_wide = 1'b0;
  endtask

  task automatic probe(input int sel, input logic [63:0] ha, input logic [11:0] ra,
                       input logic eh, input logic [63:0] eo, input logic [31:0] er,
                       input string tag);
    exp_t e;
    @(posedge clk); #1;
    host_addr = ha; rd_addr = ra;
    e.sel = sel; e.hit = eh; e.off = eo; e.rd = er; e.tag = tag;
    exp_q.push_back(e);
    probe_v = 1'b1;
    @(posedge clk); #1;
    probe_v = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] b, wb, vb;
    b  = 64'h0000_0001_8000_3000;
    wb = 64'hFFFF_FFFF_FFC0_0000;
    vb = 64'hFFFF_FFFF_FF80_0000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    probe(0, b, A_LOC, 0, 0, 0, "R1 location");
    probe(0, b, A_SZ,  0, 0, 0, "R1 size");
    probe(0, b, A_STS, 0, 0, 0, "R1 status");
    probe(0, b, A_LO,  0, 0, 0, "R1 ctrl");
    probe(1, BAR + 64'h10, A_LOC, 1, 64'h10, LOCV, "R12 legacy open at reset");
    probe(1, BAR + 64'h10, A_SZ,  1, 64'h10, SZV,  "R12 legacy size at reset");

    // high half first: nothing opens
    wr(A_HI, 32'h1);
    probe(0, b, A_HI, 0, 0, 32'h1, "R2 high half readback");
    probe(0, b, A_LO, 0, 0, 0,     "R9 high write no enable");

    // both enables, base from merged control word
    wr(A_LO, 32'h8000_3003);
    probe(0, b, A_LOC, 1, 0, LOCV, "R4 location filled");
    probe(0, b, A_SZ,  1, 0, SZV,  "R4 size filled");
    probe(0, b + WIN - 1, A_LO, 1, WIN - 1, 32'h8000_3003, "R13 last byte");
    probe(0, b + WIN, A_LO, 0, 0, 32'h8000_3003, "R6 one past end");
    probe(0, b - 1,   A_LO, 0, 0, 32'h8000_3003, "R6 below base");
    probe(0, b + 64'h1234, A_HI, 1, 64'h1234, 32'h1, "R10 offset");
    probe(2, b, A_LO,  0, 0, 0, "R3 ctrl lo ignored");
    probe(2, b, A_HI,  0, 0, 0, "R3 ctrl hi ignored");
    probe(2, b, A_LOC, 0, 0, 0, "R3 location stays clear");
    probe(1, b, A_LOC, 0, 0, LOCV, "R12 legacy ignores programmed base");
    probe(1, BAR + 64'h20, A_SZ, 1, 64'h20, SZV, "R12 legacy decodes bar base");

    // read-only size word
    wr(A_SZ, 32'h0);
    probe(0, b, A_SZ, 1, 0, SZV, "R11 size write ignored");

    // high half while open: window keeps old base
    wr(A_HI, 32'h5);
    probe(0, b, A_HI, 1, 0, 32'h5, "R9 window unchanged after high write");

    // register enable only
    wr(A_LO, 32'h0000_0001);
    probe(0, b, A_LOC, 0, 0, LOCV, "R7 closed by partial enable");
    probe(0, b, A_LO,  0, 0, 32'h1, "R2 low half readback");

    // register enable cleared
    wr(A_LO, 32'h0);
    probe(0, b, A_LOC, 0, 0, 0, "R5 location cleared");
    probe(0, b, A_SZ,  0, 0, 0, "R5 size cleared");

    // window ending exactly at 2^64 is refused
    wr(A_LO, 32'hFFC0_0003, 1'b1, 32'hFFFF_FFFF);
    probe(0, wb, A_STS, 0, 0, 32'h1, "R8 wrap refused");
    probe(0, wb, A_HI,  0, 0, 32'hFFFF_FFFF, "R2 wide write high half");
    probe(0, wb, A_LOC, 0, 0, LOCV, "R4 location on refused base");

    // one window lower is accepted; status stays set
    wr(A_LO, 32'hFF80_0003, 1'b1, 32'hFFFF_FFFF);
    probe(0, vb + WIN - 1, A_STS, 1, WIN - 1, 32'h1, "R8 top window open, status sticky");

    repeat (2) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule